// File: doc/BRIEF.md
# Self-Timed Program and Erase Sequencer

This block sits behind the serial front end of a small serial non-volatile memory. The front end decodes each instruction frame and hands over one strobe per frame, at the rising serial-clock edge that samples the frame's final bit. The strobe carries an opcode, a word address and a data word. The sequencer holds the write-enable latch and decides whether a program-type frame is really started. It runs the self-timed program cycle on its own word array, counted in system clocks, and shows busy or ready on the serial data output while the chip is selected.

A program cycle is only armed by a complete, permitted frame. It is only launched if chip select drops before the serial clock rises again. Erasing leaves words at all ones. A word write replaces the old contents without any separate erase. The serial clock edges reach the block as single-cycle strobes synchronous to the system clock, and the synchronous reset stands for power-on reset.

Top module: `pe_sequencer`

## Requirements
- R1: After reset the write-enable latch is off, and the data output is not driven (`do_oe` = 0) even with `cs` high.
- R2: The opcode codes on `req_op` are WRITE=1, ERASE=2, WRAL=3, ERAL=4, ENABLE=5, DISABLE=6, READ=7 and none=0. The four program-type codes (1 to 4) start no cycle and change no word while the latch is off. ENABLE sets the latch and DISABLE clears it.
- R3: `rd_data` always equals the stored word at `rd_addr`, whether the latch is on or off.
- R4: An armed frame launches a cycle only when `cs` falls after the strobe cycle and before the next `sk_rise`. If `sk_rise` comes first, or comes in the same clock as the `cs` fall, the frame is dropped and no word changes.
- R5: Busy lasts exactly PROG_CYCLES clocks, starting with the clock edge that sees `cs` low. The array keeps its old contents until the final busy edge.
- R6: WRITE stores `req_data` at `req_addr`, fully replacing the earlier value. It leaves every other word alone.
- R7: ERASE sets the addressed word to all ones. ERAL sets every word to all ones.
- R8: WRAL stores `req_data` into every word.
- R9: With `cs` high after a launch, `do_oe` is 1 and `do_out` is 0 while busy, then 1 once the cycle has ended.
- R10: An `sk_rise` with `di` = 1 while status is shown turns `do_oe` off at the next `sk_fall`. The output stays off until the next launch.
- R11: Frames received while busy are ignored, including ENABLE and DISABLE.
- R12: `do_oe` is never 1 while `cs` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset (power-on) |
| cs | input | 1 | Chip select level |
| di | input | 1 | Serial data-in level |
| sk_rise | input | 1 | One-clock strobe for a rising serial-clock edge |
| sk_fall | input | 1 | One-clock strobe for a falling serial-clock edge |
| req_valid | input | 1 | Decoded frame strobe, coincident with the last-bit `sk_rise` |
| req_op | input | 3 | Decoded opcode (codes in R2) |
| req_addr | input | AW | Word address of the frame |
| req_data | input | DW | Data word of the frame |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Stored word at `rd_addr` |
| do_out | output | 1 | Status level on the data output |
| do_oe | output | 1 | Data output drive enable |

## Verification
The bound checker watches several rules on every clock. A launch needs the latch and a `cs` fall with no `sk_rise` in the same clock. A dropped window never launches, and nothing launches while busy. Each busy run has exactly PROG_CYCLES clocks, and the array write is the last busy clock. The status level matches busy whenever it is driven, the output is released only at an `sk_fall` or with `cs` low, and it is never driven while deselected. What each opcode actually leaves in the array can only be shown by the bench's directed scenarios, which read the words back through `rd_addr`. The same holds for how the latch persists across ignored frames and whether a dropped frame leaves data intact.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WRAL  = 3'd3,
    OP_ERAL  = 3'd4,
    OP_EWEN  = 3'd5,
    OP_EWDS  = 3'd6,
    OP_READ  = 3'd7
  } op_e;

  // program-type opcodes go through the self-timed cycle
  function automatic logic is_prog_op(op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_WRAL) || (op == OP_ERAL);
  endfunction

  // opcodes whose stored value is all ones
  function automatic logic is_erase_op(op_e op);
    return (op == OP_ERASE) || (op == OP_ERAL);
  endfunction

  // opcodes touching every word
  function automatic logic is_all_op(op_e op);
    return (op == OP_WRAL) || (op == OP_ERAL);
  endfunction

endpackage

// File: rtl/pe_wel.sv
module pe_wel
  import pe_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  op_e  op,
  output logic wen
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wen <= 1'b0;
    end else if (accept) begin
      if (op == OP_EWEN) wen <= 1'b1;
      else if (op == OP_EWDS) wen <= 1'b0;
    end
  end

endmodule

// File: rtl/pe_window.sv
module pe_window
  import pe_seq_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  op_e           op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          cs,
  input  logic          sk_rise,
  output logic          pending,
  output logic          launch,
  output op_e           h_op,
  output logic [AW-1:0] h_addr,
  output logic [DW-1:0] h_data
);

  logic cs_q;
  logic cs_fall;

  assign cs_fall = cs_q && !cs;
  // a rising serial edge closes the window, even in the same clock as the fall
  assign launch  = pending && cs_fall && !sk_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b0;
      pending <= 1'b0;
      h_op    <= OP_NONE;
      h_addr  <= '0;
      h_data  <= '0;
    end else begin
      cs_q <= cs;
      if (arm) begin
        pending <= 1'b1;
        h_op    <= op;
        h_addr  <= addr;
        h_data  <= data;
      end else if (pending && (sk_rise || cs_fall)) begin
        pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pe_timer.sv
module pe_timer #(
  parameter int PROG_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= CW'(PROG_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/pe_status.sv
module pe_status (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic di,
  input  logic sk_rise,
  input  logic sk_fall,
  input  logic launch,
  input  logic busy,
  output logic do_out,
  output logic do_oe
);

  logic show;
  logic release_req;

  assign do_oe  = cs && show;
  assign do_out = show && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      show        <= 1'b0;
      release_req <= 1'b0;
    end else if (launch) begin
      show        <= 1'b1;
      release_req <= 1'b0;
    end else if (!cs) begin
      release_req <= 1'b0;
    end else if (sk_fall && release_req) begin
      show        <= 1'b0;
      release_req <= 1'b0;
    end else if (sk_rise && di && show) begin
      release_req <= 1'b1;
    end
  end

endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
  import pe_seq_pkg::*;
#(
  parameter int AW          = 4,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          di,
  input  logic          sk_rise,
  input  logic          sk_fall,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          do_out,
  output logic          do_oe
);

  localparam int DEPTH = 1 << AW;

  op_e           op_in;
  op_e           h_op;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data;
  logic          wen, busy, pending, launch, wr_fire;
  logic          accept, arm;
  logic [DW-1:0] wr_word;
  logic [DW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] hit;

  function automatic logic [DW-1:0] fill_word(op_e op, logic [DW-1:0] d);
    return is_erase_op(op) ? {DW{1'b1}} : d;
  endfunction

  assign op_in  = op_e'(req_op);
  assign accept = req_valid && cs && !busy;
  assign arm    = accept && wen && is_prog_op(op_in);

  pe_wel wel_i (
    .clk(clk), .rst(rst), .accept(accept), .op(op_in), .wen(wen)
  );

  pe_window #(.AW(AW), .DW(DW)) win_i (
    .clk(clk), .rst(rst), .arm(arm), .op(op_in), .addr(req_addr), .data(req_data),
    .cs(cs), .sk_rise(sk_rise), .pending(pending), .launch(launch),
    .h_op(h_op), .h_addr(h_addr), .h_data(h_data)
  );

  pe_timer #(.PROG_CYCLES(PROG_CYCLES)) tmr_i (
    .clk(clk), .rst(rst), .launch(launch), .busy(busy), .done(wr_fire)
  );

  pe_status st_i (
    .clk(clk), .rst(rst), .cs(cs), .di(di), .sk_rise(sk_rise), .sk_fall(sk_fall),
    .launch(launch), .busy(busy), .do_out(do_out), .do_oe(do_oe)
  );

  assign wr_word = fill_word(h_op, h_data);

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit[g] = wr_fire && (is_all_op(h_op) || (h_addr == AW'(g)));
  end

  // array is non-volatile: reset leaves it untouched
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) mem[i] <= wr_word;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pe_sequencer_chk.sv
module pe_sequencer_chk #(
  parameter int PROG_CYCLES = 8
) (
  input logic clk,
  input logic rst,
  input logic cs,
  input logic sk_rise,
  input logic sk_fall,
  input logic do_out,
  input logic do_oe,
  input logic wen,
  input logic busy,
  input logic pending,
  input logic launch,
  input logic wr_fire
);

  int run_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= 0;
    else              run_len <= run_len + 1;
  end

  a_r1_disabled_after_reset: assert property (@(posedge clk) rst |=> !wen);

  a_r2_launch_needs_wen: assert property (@(posedge clk) disable iff (rst)
    launch |-> wen);

  a_r4_launch_on_cs_fall: assert property (@(posedge clk) disable iff (rst)
    launch |-> (!cs && $past(cs) && !sk_rise));

  a_r4_window_closed: assert property (@(posedge clk) disable iff (rst)
    (pending && sk_rise) |-> !launch);

  a_r5_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == PROG_CYCLES));

  a_r5_write_at_end: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> !busy);

  a_r9_busy_low: assert property (@(posedge clk) disable iff (rst)
    (do_oe && busy) |-> !do_out);

  a_r9_ready_high: assert property (@(posedge clk) disable iff (rst)
    (do_oe && !busy) |-> do_out);

  a_r10_release_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(do_oe) |-> (!cs || $past(sk_fall)));

  a_r11_no_launch_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !launch);

  a_r12_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs |-> !do_oe);

endmodule

bind pe_sequencer pe_sequencer_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .cs(cs), .sk_rise(sk_rise), .sk_fall(sk_fall),
  .do_out(do_out), .do_oe(do_oe), .wen(wen), .busy(busy), .pending(pending),
  .launch(launch), .wr_fire(wr_fire)
);

// File: tb/pe_sequencer_tb_top.sv
module pe_sequencer_tb_top;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int P  = 8;
  localparam int DEPTH = 1 << AW;

  localparam logic [2:0] C_WRITE = 3'd1, C_ERASE = 3'd2, C_WRAL = 3'd3,
                         C_ERAL = 3'd4, C_EN = 3'd5, C_DIS = 3'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, di = 1'b0, sk_rise = 1'b0, sk_fall = 1'b0, req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0, rd_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [DW-1:0] rd_data;
  logic          do_out, do_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #4 clk = ~clk;

  pe_sequencer #(.AW(AW), .DW(DW), .PROG_CYCLES(P)) dut_i (
    .clk(clk), .rst(rst), .cs(cs), .di(di), .sk_rise(sk_rise), .sk_fall(sk_fall),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .do_out(do_out), .do_oe(do_oe)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected effect of a launched cycle
  task automatic model(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    for (int i = 0; i < DEPTH; i++) begin
      if (op == C_ERAL) ref_mem[i] = '1;
      if (op == C_WRAL) ref_mem[i] = d;
    end
    if (op == C_ERASE) ref_mem[a] = '1;
    if (op == C_WRITE) ref_mem[a] = d;
  endtask

  // frame strobe with its last-bit rising edge, then one falling edge
  task automatic frame(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    cs = 1'b1; di = 1'b0;
    req_valid = 1'b1; sk_rise = 1'b1; req_op = op; req_addr = a; req_data = d;
    tick();
    req_valid = 1'b0; sk_rise = 1'b0; sk_fall = 1'b1;
    tick();
    sk_fall = 1'b0;
  endtask

  // reselect and count clocks of busy status until ready
  task automatic count_busy(output int n);
    cs = 1'b1; #1;
    n = 0;
    while (do_oe === 1'b1 && do_out === 1'b0 && n < 4 * P) begin
      n++;
      tick();
    end
  endtask

  task automatic cycle(string tag, logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                       bit expect_run);
    int n;
    frame(op, a, d);
    cs = 1'b0; tick();
    count_busy(n);
    chk({tag, " busy length"}, n, expect_run ? P : 0);
    if (expect_run) begin
      model(op, a, d);
      chk({tag, " ready shown"}, {do_oe, do_out}, 2'b11);
    end
    cs = 1'b0; tick();
  endtask

  task automatic check_word(string tag, logic [AW-1:0] a);
    rd_addr = a; #1;
    chk(tag, rd_data, ref_mem[a]);
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < DEPTH; i++) check_word(tag, AW'(i));
  endtask

  task automatic t_reset();
    cs = 1'b1; #1;
    chk("R1 output released after reset", do_oe, 1'b0);
    cs = 1'b0; tick();
  endtask

  task automatic t_locked();
    cycle("R2 write while locked", C_WRITE, 4'd3, 16'h1111, 1'b0);
    cs = 1'b1; #1;
    chk("R1 no status while locked", do_oe, 1'b0);
    cs = 1'b0; tick();
  endtask

  task automatic t_enable_eral();
    frame(C_EN, '0, '0); cs = 1'b0; tick();
    cycle("R7 R9 eral", C_ERAL, '0, '0, 1'b1);
    check_all("R7 eral all ones");
  endtask

  task automatic t_write();
    cycle("R6 write", C_WRITE, 4'd5, 16'h1234, 1'b1);
    check_word("R6 word 5", 4'd5);
    check_word("R6 neighbour 4", 4'd4);
    check_word("R6 neighbour 6", 4'd6);
    cycle("R6 overwrite", C_WRITE, 4'd5, 16'h00F0, 1'b1);
    check_word("R6 overwrite without erase", 4'd5);
  endtask

  task automatic t_midcycle();
    logic [DW-1:0] old;
    old = ref_mem[7];
    frame(C_WRITE, 4'd7, 16'hBEEF);
    cs = 1'b0; tick();
    rd_addr = 4'd7;
    for (int i = 0; i < P - 1; i++) begin
      #1 chk("R5 array unchanged while busy", rd_data, old);
      tick();
    end
    tick(); tick();
    model(C_WRITE, 4'd7, 16'hBEEF);
    check_word("R5 array updated at end", 4'd7);
  endtask

  task automatic t_erase_wral();
    cycle("R7 erase", C_ERASE, 4'd5, '0, 1'b1);
    check_word("R7 erase word 5", 4'd5);
    check_word("R7 erase keeps 7", 4'd7);
    cycle("R8 wral", C_WRAL, '0, 16'hA5C3, 1'b1);
    check_all("R8 wral every word");
    cycle("R7 erase after wral", C_ERASE, 4'd2, '0, 1'b1);
    check_word("R7 word 2 ones", 4'd2);
    check_word("R8 word 3 kept", 4'd3);
  endtask

  task automatic t_disable();
    frame(C_DIS, '0, '0); cs = 1'b0; tick();
    cycle("R2 write after disable", C_WRITE, 4'd1, 16'h0001, 1'b0);
    check_word("R3 read while disabled", 4'd1);
    cycle("R2 eral after disable", C_ERAL, '0, '0, 1'b0);
    check_word("R3 read word 3 disabled", 4'd3);
    frame(C_EN, '0, '0); cs = 1'b0; tick();
  endtask

  task automatic t_window();
    int n;
    // late fall: an extra rising edge before CS drops
    frame(C_WRITE, 4'd0, 16'h7777);
    sk_rise = 1'b1; tick(); sk_rise = 1'b0;
    cs = 1'b0; tick();
    count_busy(n);
    chk("R4 late fall no cycle", n, 0);
    cs = 1'b0; tick();
    check_word("R4 word 0 unchanged", 4'd0);
    // fall together with a rising edge
    frame(C_WRITE, 4'd0, 16'h8888);
    cs = 1'b0; sk_rise = 1'b1; tick(); sk_rise = 1'b0;
    count_busy(n);
    chk("R4 same-clock fall no cycle", n, 0);
    cs = 1'b0; tick();
    check_word("R4 word 0 still unchanged", 4'd0);
    cycle("R4 fall in window", C_WRITE, 4'd0, 16'h9999, 1'b1);
    check_word("R4 window write lands", 4'd0);
  endtask

  task automatic t_release();
    cs = 1'b1; #1;
    chk("R9 ready on reselect", {do_oe, do_out}, 2'b11);
    di = 1'b1; sk_rise = 1'b1; tick();
    di = 1'b0; sk_rise = 1'b0; #1;
    chk("R10 still driven before fall", do_oe, 1'b1);
    sk_fall = 1'b1; tick(); sk_fall = 1'b0; #1;
    chk("R10 released after fall", do_oe, 1'b0);
    tick();
    chk("R10 stays released", do_oe, 1'b0);
    cs = 1'b0; #1;
    chk("R12 quiet when deselected", do_oe, 1'b0);
    tick();
    cs = 1'b1; #1;
    chk("R10 released across selection", do_oe, 1'b0);
    cs = 1'b0; tick();
  endtask

  task automatic t_busy_ignore();
    int n;
    frame(C_WRITE, 4'd9, 16'h0909);
    cs = 1'b0; tick();
    cs = 1'b1; tick();
    frame(C_DIS, '0, '0);
    frame(C_WRITE, 4'd10, 16'h1010);
    cs = 1'b0; tick();
    count_busy(n);
    chk("R11 first cycle still running", n > 0, 1'b1);
    cs = 1'b0; tick();
    model(C_WRITE, 4'd9, 16'h0909);
    check_word("R11 word 9 written", 4'd9);
    check_word("R11 word 10 ignored", 4'd10);
    cycle("R11 enable survived", C_WRITE, 4'd10, 16'h1010, 1'b1);
    check_word("R11 word 10 now written", 4'd10);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_locked();
    t_enable_eral();
    t_write();
    t_midcycle();
    t_erase_wral();
    t_disable();
    t_window();
    t_release();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule